// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset causes into one active-low internal reset. The causes are an external active-low reset pin, a supply-good signal from a power-on detector, and a low-voltage indication from a supply monitor. The pin and the power-on input pull the internal reset low at once, without waiting for a clock edge. The low-voltage input passes through a synchronizer first. Each cause has its own release timer, which starts when that cause goes away. The internal reset is released on a clock edge, and only after every timer has run out. In the first cycle after release, a one-cycle pulse tells the processor to begin its reset handling.

Two sticky flags record why the chip was reset: one for power-on and one for low voltage. Software reads them through a small register port and may clear the low-voltage flag. The low-voltage cause is enabled by a static option input that is active low: when the option is 1, the low-voltage input is ignored. The comparators and the threshold logic sit outside this block. Only their digital outputs arrive here.

Top module: `reset_sequencer`

## Requirements
- R1: While `pin_rst_n` is 0 or `por_ok` is 0, `rst_out_n` is 0. It falls immediately, with no clock edge needed.
- R2: When `pin_rst_n` rises and no other cause is pending, `rst_out_n` rises after the PIN_WAIT+3rd rising clock edge (7 with the defaults).
- R3: When `por_ok` rises, `rst_out_n` rises after the POR_WAIT+3rd edge (11 with the defaults). While `por_ok` is 0, the power-on flag at `reg_rdata[0]` reads 1, and it stays 1 after release.
- R4: A pin reset clears the power-on flag. A software write does not change it.
- R5: When `lv_off` is 0, a high `lv_low` drives `rst_out_n` to 0 within three clock edges and sets the low-voltage flag at `reg_rdata[1]`.
- R6: When `lv_off` is 1, `lv_low` has no effect on `rst_out_n` and does not set the low-voltage flag.
- R7: After `lv_low` falls, `rst_out_n` rises after the LV_WAIT+3rd edge (9 with the defaults).
- R8: `boot_pulse` is 1 for exactly one cycle: the first cycle in which `rst_out_n` is 1.
- R9: If a cause asserts again while its release timer is counting, the timer restarts from its full value when the cause deasserts once more.
- R10: Each of the following clears the low-voltage flag: a pin reset, a power-on reset, or a write (`reg_wr`=1) with `reg_wlv`=0. A write with `reg_wlv`=1 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External reset pin, active low |
| por_ok | input | 1 | Supply above the power-on threshold |
| lv_low | input | 1 | Supply below the low-voltage detection level |
| lv_off | input | 1 | Low-voltage reset option, 0 = enabled |
| reg_wr | input | 1 | Write strobe for the flag register |
| reg_wlv | input | 1 | Write data for the low-voltage flag; only 0 has an effect |
| reg_rdata | output | 2 | Flags: bit 0 = power-on, bit 1 = low-voltage |
| rst_out_n | output | 1 | Internal reset, active low |
| boot_pulse | output | 1 | One-cycle start-of-reset-handling pulse |

## Verification
The ports reveal a faulty timer or synchronizer as a release latency that is off by whole cycles. So each release is measured edge by edge from the moment its cause deasserts, and compared against that cause's own wait. A flag that is set or cleared by the wrong cause appears in `reg_rdata` on the clock edge after that cause. It is therefore read back after every reset event and after every write. A lost restart or a missing async path shows up as `rst_out_n` rising too early, or failing to fall, before the next clock edge.

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer #(
  parameter int PIN_WAIT = 4,
  parameter int POR_WAIT = 8,
  parameter int LV_WAIT  = 6
) (
  input  logic       clk,
  input  logic       pin_rst_n,
  input  logic       por_ok,
  input  logic       lv_low,
  input  logic       lv_off,
  input  logic       reg_wr,
  input  logic       reg_wlv,
  output logic [1:0] reg_rdata,
  output logic       rst_out_n,
  output logic       boot_pulse
);
  localparam int MAXW = (PIN_WAIT > POR_WAIT) ?
                        ((PIN_WAIT > LV_WAIT) ? PIN_WAIT : LV_WAIT) :
                        ((POR_WAIT > LV_WAIT) ? POR_WAIT : LV_WAIT);
  localparam int CW = $clog2(MAXW + 1);

  logic          arst_n;
  logic [1:0]    pin_sy, por_sy, lv_sy;
  logic          pin_act_s, por_act_s, lv_src, pin_src;
  logic [CW-1:0] pin_cnt, por_cnt, lv_cnt;
  logic          pending, rel_q, rel_d;
  logic          por_flag, lv_flag;

  assign arst_n = pin_rst_n & por_ok;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) pin_sy <= 2'b11;
    else         pin_sy <= {pin_sy[0], 1'b0};

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok) por_sy <= 2'b11;
    else         por_sy <= {por_sy[0], 1'b0};

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) lv_sy <= 2'b00;
    else         lv_sy <= {lv_sy[0], lv_low};

  assign pin_act_s = pin_sy[1];
  assign por_act_s = por_sy[1];
  assign pin_src   = pin_act_s & ~por_act_s;
  assign lv_src    = ~lv_off & lv_sy[1];

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              pin_cnt <= '0;
    else if (pin_src)         pin_cnt <= CW'(PIN_WAIT);
    else if (pin_cnt != '0)   pin_cnt <= pin_cnt - 1'b1;

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok)              por_cnt <= '0;
    else if (por_act_s)       por_cnt <= CW'(POR_WAIT);
    else if (por_cnt != '0)   por_cnt <= por_cnt - 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              lv_cnt <= '0;
    else if (lv_src)          lv_cnt <= CW'(LV_WAIT);
    else if (lv_cnt != '0)    lv_cnt <= lv_cnt - 1'b1;

  assign pending = pin_src | (pin_cnt != '0) | por_act_s | (por_cnt != '0) |
                   lv_src | (lv_cnt != '0);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      rel_q <= 1'b0;
      rel_d <= 1'b0;
    end else begin
      rel_q <= ~pending;
      rel_d <= rel_q;
    end

  assign rst_out_n  = rel_q;
  assign boot_pulse = rel_q & ~rel_d;

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok)        por_flag <= 1'b1;
    else if (por_act_s) por_flag <= 1'b1;
    else if (pin_act_s) por_flag <= 1'b0;

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok)                         lv_flag <= 1'b0;
    else if (por_act_s || pin_act_s)     lv_flag <= 1'b0;
    else if (lv_src)                     lv_flag <= 1'b1;
    else if (reg_wr && !reg_wlv)         lv_flag <= 1'b0;

  assign reg_rdata = {lv_flag, por_flag};
endmodule

// File: rtl/reset_sequencer_chk.sv
`timescale 1ns/1ps
module reset_sequencer_chk (
  input logic       clk,
  input logic       pin_rst_n,
  input logic       por_ok,
  input logic       lv_off,
  input logic [1:0] reg_rdata,
  input logic       rst_out_n,
  input logic       boot_pulse,
  input logic       pin_act
);
  AST_PIN_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_ok)
    !pin_rst_n |-> !rst_out_n); // R1
  AST_BOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!(pin_rst_n && por_ok))
    boot_pulse |=> !boot_pulse); // R8
  AST_BOOT_ON_RELEASE: assert property (@(posedge clk) disable iff (!(pin_rst_n && por_ok))
    $rose(rst_out_n) |-> boot_pulse); // R8
  AST_LV_FLAG_ENABLED: assert property (@(posedge clk) disable iff (!por_ok)
    $rose(reg_rdata[1]) |-> !lv_off); // R6
  AST_POR_FLAG_PIN_CLEAR: assert property (@(posedge clk) disable iff (!por_ok)
    $fell(reg_rdata[0]) |-> $past(pin_act)); // R4
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (
  .clk(clk), .pin_rst_n(pin_rst_n), .por_ok(por_ok), .lv_off(lv_off),
  .reg_rdata(reg_rdata), .rst_out_n(rst_out_n), .boot_pulse(boot_pulse),
  .pin_act(pin_act_s)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
  logic clk = 1'b0;
  logic pin_rst_n = 1'b1, por_ok = 1'b1, lv_low = 1'b0, lv_off = 1'b0;
  logic reg_wr = 1'b0, reg_wlv = 1'b1;
  logic [1:0] reg_rdata;
  logic rst_out_n, boot_pulse;
  int checks = 0, errors = 0;

  localparam int PIN_LAT = 7, POR_LAT = 11, LV_LAT = 9;
  localparam int NV = 4;
  localparam int V_KIND[NV] = '{1, 0, 1, 0};
  localparam int V_HOLD[NV] = '{5, 3, 3, 8};
  localparam int V_LAT [NV] = '{LV_LAT, PIN_LAT, LV_LAT, PIN_LAT};
  localparam int V_FLG [NV] = '{3, 0, 2, 0};

  always #10 clk = ~clk;

  reset_sequencer u_reset_sequencer (
    .clk(clk), .pin_rst_n(pin_rst_n), .por_ok(por_ok), .lv_low(lv_low),
    .lv_off(lv_off), .reg_wr(reg_wr), .reg_wlv(reg_wlv), .reg_rdata(reg_rdata),
    .rst_out_n(rst_out_n), .boot_pulse(boot_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input string req, input int exp_lat);
    int lat = 0;
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (rst_out_n !== 1'b1 && lat < 60);
    chk(req, lat, exp_lat);
    chk("R8 pulse high", int'(boot_pulse), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(boot_pulse), 0);
  endtask

  task automatic sw_write(input logic v);
    reg_wr = 1'b1; reg_wlv = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wlv = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5 por_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state rst_out_n", int'(rst_out_n), 0);
    chk("R8 reset state boot_pulse", int'(boot_pulse), 0);
    chk("R3 por flag during power-on", int'(reg_rdata), 1);
    por_ok = 1'b1;
    measure("R3 power-on latency", POR_LAT);
    chk("R3 flags after power-on", int'(reg_rdata), 1);

    for (int i = 0; i < NV; i++) begin
      if (V_KIND[i] == 1) lv_low = 1'b1; else pin_rst_n = 1'b0;
      repeat (V_HOLD[i]) @(negedge clk);
      chk(V_KIND[i] == 1 ? "R5 lv asserts reset" : "R1 pin asserts reset", int'(rst_out_n), 0);
      if (V_KIND[i] == 1) lv_low = 1'b0; else pin_rst_n = 1'b1;
      measure(V_KIND[i] == 1 ? "R7 lv latency" : "R2 pin latency", V_LAT[i]);
      chk(V_KIND[i] == 1 ? "R5 flags after lv" : "R4 R10 flags after pin", int'(reg_rdata), V_FLG[i]);
    end

    pin_rst_n = 1'b0;
    #2 chk("R1 immediate pin assertion", int'(rst_out_n), 0);
    @(negedge clk);
    pin_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 pin still counting", int'(rst_out_n), 0);
    pin_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pin_rst_n = 1'b1;
    measure("R9 pin restart latency", PIN_LAT);

    lv_low = 1'b1;
    repeat (3) @(negedge clk);
    lv_low = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 lv still counting", int'(rst_out_n), 0);
    lv_low = 1'b1;
    repeat (3) @(negedge clk);
    lv_low = 1'b0;
    measure("R9 lv restart latency", LV_LAT);
    chk("R5 lv flag set", int'(reg_rdata), 2);

    sw_write(1'b1);
    chk("R10 write 1 no effect", int'(reg_rdata), 2);
    sw_write(1'b0);
    chk("R10 write 0 clears lv flag", int'(reg_rdata), 0);

    lv_off = 1'b1;
    @(negedge clk);
    lv_low = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rst_out_n !== 1'b1) chk("R6 disabled lv no reset", int'(rst_out_n), 1);
    end
    chk("R6 disabled lv no reset", int'(rst_out_n), 1);
    lv_low = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 disabled lv no flag", int'(reg_rdata), 0);
    lv_off = 1'b0;
    @(negedge clk);

    por_ok = 1'b0;
    #2 chk("R1 immediate power-on assertion", int'(rst_out_n), 0);
    repeat (2) @(negedge clk);
    por_ok = 1'b1;
    measure("R3 power cycle latency", POR_LAT);
    chk("R3 por flag after power cycle", int'(reg_rdata), 1);

    lv_low = 1'b1;
    repeat (3) @(negedge clk);
    lv_low = 1'b0;
    measure("R7 lv latency", LV_LAT);
    chk("R5 both flags", int'(reg_rdata), 3);
    sw_write(1'b0);
    chk("R4 write keeps por flag", int'(reg_rdata), 1);

    lv_low = 1'b1;
    repeat (3) @(negedge clk);
    lv_low = 1'b0;
    measure("R7 lv latency", LV_LAT);
    chk("R5 lv flag set again", int'(reg_rdata), 3);
    por_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 power-on clears lv flag", int'(reg_rdata), 1);
    por_ok = 1'b1;
    measure("R3 final power-on latency", POR_LAT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule